// File: doc/BRIEF.md
# Periodic Interrupt and Event Flag Unit

This block turns a 32.768 kHz time-base enable pulse into a programmable periodic interrupt and a matching square wave. A 4-bit logarithmic rate code selects the period. The block also collects three event sources into one flag register: the periodic event, an alarm match and an update-ended pulse. A summary interrupt line is raised when any flagged source is also enabled.

Software uses a small byte-wide register bus to reach three registers. The divider register holds the time-base selection and the rate code. The enable register holds the square-wave enable and the three interrupt enables. The flag register is read-only and clears when read. The alarm and update-ended pulses come from a neighbouring time-of-day block. The irq and sqw outputs are plain levels.

The bus has no back-pressure. The block accepts a write on every cycle in which `bus_sel` and `bus_wr` are both high. Read data is valid in the same cycle as `bus_sel` and `bus_rd`. No input stream can stall and no output is held back.

Top module: `pirq_gen`

## Requirements
- R1: The rate field is bits 3:0 of the divider register. With the 32 kHz base selected and a rate code from 3 to 15, a periodic event fires once every 2^(code-1) time-base pulses. Code 3 is therefore 8192 Hz and code 15 is 2 Hz.
- R2: With the 32 kHz base, rate code 1 gives a periodic event every 128 pulses (256 Hz) and code 2 gives one every 256 pulses (128 Hz).
- R3: Rate code 0 produces no periodic event and keeps sqw low.
- R4: The base field is bits 6:4 of the divider register. Value 3'b010 lets the prescaler count time-base pulses. Values 3'b110 and 3'b111 hold the prescaler at zero, so after a return to 3'b010 the first periodic event arrives one full period later. Any other value freezes the prescaler at its current count.
- R5: The flag register (address 2) has three event bits: bit 4 is the update-ended flag, bit 5 the alarm flag and bit 6 the periodic flag. Each bit sets on its event whatever the enables hold.
- R6: The enable register (address 1) has four bits. Bit 3 enables the square wave, bit 4 the update-ended interrupt, bit 5 the alarm interrupt and bit 6 the periodic interrupt. Flag bit 7 and the irq output are 1 exactly when some event flag is set and its matching enable is 1.
- R7: A read of address 2 returns the current flags and then clears all of them. An event in the same cycle as the read stays set. Bits 3:0 of the flag register always read 0.
- R8: sqw is low for the first half of each periodic interval and high for the second half, so its frequency equals the periodic rate. It is held low while enable bit 3 is 0.
- R9: Address 0 reads back bits 6:0 as written, and bit 7 reads 0. Address 1 reads back bits 6:3 as written, and its other bits read 0. Address 3 reads 0. Writes to addresses 2 and 3 have no effect.
- R10: After reset every register and flag is 0, and irq and sqw are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle pulse per 32.768 kHz time-base period |
| alarm_match | input | 1 | One-cycle alarm event pulse |
| update_ended | input | 1 | One-cycle update-ended event pulse |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while selected and reading |
| irq | output | 1 | Interrupt request level |
| sqw | output | 1 | Square-wave output |

## Verification
A prescaler count that drifts by even one pulse moves the periodic flag and the sqw edge off their expected cycles. The per-cycle comparison of sqw shows the error within one half-period. A flag bit that fails to clear or set, or a wrong enable mapping, appears on irq in the cycle after the event or the read. The next flag read shows it on the bus at once. The reference model tracks the count, the flags and the registers every cycle, so every mismatch is reported in the cycle it first reaches a port.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int NUM_SRC = 3;

  localparam logic [ADDR_W-1:0] ADR_DIV = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_ENA = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_FLG = 2'd2;

  localparam logic [2:0] BASE_32K = 3'b010;

  // event source order inside the flag vector (flag bit = 4 + index)
  typedef enum logic [1:0] {
    SRC_UPD = 2'd0,
    SRC_ALM = 2'd1,
    SRC_PER = 2'd2
  } src_e;

  // stored enable vector: [0] square wave, [1] update, [2] alarm, [3] periodic
  localparam int ENA_SQW = 0;

  function automatic logic base_holds(input logic [2:0] b);
    return b[2:1] == 2'b11;
  endfunction
endpackage

// File: rtl/pirq_rate_dec.sv
module pirq_rate_dec #(
  parameter int CNT_W = 15
) (
  input  logic [3:0]       code,
  output logic             active,
  output logic [CNT_W-1:0] period_mask,
  output logic [CNT_W-1:0] half_tap
);
  int expo;

  always_comb begin
    if (code == 4'd1)      expo = 7;
    else if (code == 4'd2) expo = 8;
    else if (code == 4'd0) expo = 0;
    else                   expo = int'(code) - 1;
    active = (code != 4'd0);
    for (int i = 0; i < CNT_W; i++) begin
      period_mask[i] = active && (i < expo);
      half_tap[i]    = active && (i == expo - 1);
    end
  end
endmodule

// File: rtl/pirq_prescaler.sv
module pirq_prescaler #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             hold_clr,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (hold_clr)    count <= '0;
    else if (run && tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/pirq_flags.sv
module pirq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         rd_clr,
  output logic [N-1:0] flg
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flg[g] <= 1'b0;
      else if (rd_clr) flg[g] <= evt[g];
      else if (evt[g]) flg[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/pirq_gen.sv
module pirq_gen
  import pirq_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              alarm_match,
  input  logic              update_ended,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sqw
);
  logic [6:0]         div_q;
  logic [3:0]         en_q;
  logic [NUM_SRC-1:0] flg;
  logic [NUM_SRC-1:0] evt;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   pmask;
  logic [CNT_W-1:0]   tap;
  logic               rate_on;
  logic               run;
  logic               hold;
  logic               pev;
  logic               wr_div;
  logic               wr_ena;
  logic               rd_flg;
  logic               irq_sum;

  assign wr_div = bus_sel && bus_wr && (bus_addr == ADR_DIV);
  assign wr_ena = bus_sel && bus_wr && (bus_addr == ADR_ENA);
  assign rd_flg = bus_sel && bus_rd && (bus_addr == ADR_FLG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      en_q  <= '0;
    end else begin
      if (wr_div) div_q <= bus_wdata[6:0];
      if (wr_ena) en_q  <= bus_wdata[6:3];
    end
  end

  assign run  = (div_q[6:4] == BASE_32K);
  assign hold = base_holds(div_q[6:4]);

  pirq_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_32k),
    .run      (run),
    .hold_clr (hold),
    .count    (cnt)
  );

  pirq_rate_dec #(.CNT_W(CNT_W)) u_dec (
    .code        (div_q[3:0]),
    .active      (rate_on),
    .period_mask (pmask),
    .half_tap    (tap)
  );

  // event on the pulse that wraps the selected low bits of the count
  assign pev = tick_32k && run && rate_on && ((cnt & pmask) == pmask);

  always_comb begin
    evt          = '0;
    evt[SRC_UPD] = update_ended;
    evt[SRC_ALM] = alarm_match;
    evt[SRC_PER] = pev;
  end

  pirq_flags #(.N(NUM_SRC)) u_flg (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .rd_clr (rd_flg),
    .flg    (flg)
  );

  assign irq_sum = |(flg & en_q[3:1]);
  assign irq     = irq_sum;
  assign sqw     = en_q[ENA_SQW] && rate_on && (|(cnt & tap));

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && bus_rd) begin
      case (bus_addr)
        ADR_DIV: bus_rdata = {1'b0, div_q};
        ADR_ENA: bus_rdata = {1'b0, en_q, 3'b000};
        ADR_FLG: bus_rdata = {irq_sum, flg, 4'b0000};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pirq_gen_chk.sv
module pirq_gen_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alarm_match,
  input logic             update_ended,
  input logic             bus_sel,
  input logic             bus_rd,
  input logic [1:0]       bus_addr,
  input logic [7:0]       bus_rdata,
  input logic             irq,
  input logic             sqw,
  input logic [6:0]       div_q,
  input logic [3:0]       en_q,
  input logic [2:0]       flg,
  input logic             pev,
  input logic [CNT_W-1:0] cnt
);
  AST_CODE0_NO_PERIODIC: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q[3:0] == 4'd0) |-> !pev); // R3

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(div_q[6:5] == 2'b11) |-> (cnt == '0)); // R4

  AST_ALARM_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_match |=> flg[1]); // R5

  AST_UPDATE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    update_ended |=> flg[0]); // R5

  AST_NO_IRQ_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[3:1] == 3'b000) |-> !irq); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && bus_addr == 2'd2 && !pev && !alarm_match && !update_ended)
      |=> (flg == 3'b000)); // R7

  AST_FLAG_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && bus_addr == 2'd2) |-> (bus_rdata[3:0] == 4'd0)); // R7

  AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[0] || div_q[3:0] == 4'd0) |-> !sqw); // R8
endmodule

bind pirq_gen pirq_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alarm_match  (alarm_match),
  .update_ended (update_ended),
  .bus_sel      (bus_sel),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .irq          (irq),
  .sqw          (sqw),
  .div_q        (div_q),
  .en_q         (en_q),
  .flg          (flg),
  .pev          (pev),
  .cnt          (cnt)
);

// File: tb/sim_pirq_gen.sv
`timescale 1ns/1ps
module sim_pirq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic       alarm_match = 1'b0;
  logic       update_ended = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic       sqw;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int         m_cnt = 0;
  logic [6:0] m_div = '0;
  logic [7:0] m_en = '0;
  logic [2:0] m_f = '0;    // {periodic, alarm, update}
  int         tdiv = 1;
  int         ph = 0;

  always #2 clk = ~clk;

  pirq_gen u0 (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .alarm_match(alarm_match),
    .update_ended(update_ended), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sqw(sqw)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rate_exp(input logic [3:0] c);
    if (c == 4'd1) return 7;
    if (c == 4'd2) return 8;
    if (c == 4'd0) return 0;
    return int'(c) - 1;
  endfunction

  function automatic logic exp_irq();
    return |(m_f & m_en[6:4]);
  endfunction

  function automatic logic exp_sqw();
    int e;
    e = rate_exp(m_div[3:0]);
    if (!m_en[3] || m_div[3:0] == 4'd0) return 1'b0;
    return ((m_cnt >> (e - 1)) & 1) == 1;
  endfunction

  function automatic logic [7:0] model_rd(input logic [1:0] a);
    case (a)
      2'd0: return {1'b0, m_div};
      2'd1: return m_en;
      2'd2: return {exp_irq(), m_f, 4'b0000};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic nt();
    ph++;
    return (ph % tdiv) == 0;
  endfunction

  task automatic cyc(input logic tk, input logic al, input logic up, input logic wr,
                     input logic rd, input logic [1:0] a, input logic [7:0] wd, input string tag);
    logic [3:0] code;
    logic [2:0] b;
    logic       pe;
    int         e;
    tick_32k = tk; alarm_match = al; update_ended = up;
    bus_sel = wr | rd; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    #1;
    if (rd) chk(tag, bus_rdata, model_rd(a));
    code = m_div[3:0];
    b = m_div[6:4];
    e = rate_exp(code);
    pe = 1'b0;
    if (b[2:1] == 2'b11) m_cnt = 0;
    else if (b == 3'b010 && tk) begin
      if (code != 4'd0 && (m_cnt % (1 << e)) == (1 << e) - 1) pe = 1'b1;
      m_cnt = (m_cnt + 1) % 32768;
    end
    if (rd && a == 2'd2) m_f = {pe, al, up};
    else                 m_f = m_f | {pe, al, up};
    if (wr && a == 2'd0) m_div = wd[6:0];
    if (wr && a == 2'd1) m_en = wd & 8'h78;
    @(posedge clk);
    @(negedge clk);
    chk("R6 irq", {7'b0, irq}, {7'b0, exp_irq()});
    chk("R8 sqw", {7'b0, sqw}, {7'b0, exp_sqw()});
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(nt(), 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, "");
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    cyc(nt(), 1'b0, 1'b0, 1'b1, 1'b0, a, d, "");
  endtask

  task automatic rreg(input logic [1:0] a, input string tag);
    cyc(nt(), 1'b0, 1'b0, 1'b0, 1'b1, a, 8'd0, tag);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 irq", {7'b0, irq}, 8'h00);
    chk("R10 sqw", {7'b0, sqw}, 8'h00);
    rreg(2'd0, "R10 div");
    rreg(2'd1, "R10 ena");
    rreg(2'd2, "R10 flg");

    // R9: register map and ignored writes
    wreg(2'd0, 8'hFF);
    rreg(2'd0, "R9 div readback");
    wreg(2'd1, 8'hFF);
    rreg(2'd1, "R9 ena readback");
    wreg(2'd1, 8'h00);
    wreg(2'd2, 8'hFF);
    wreg(2'd3, 8'hFF);
    rreg(2'd2, "R9 flg write ignored");
    rreg(2'd3, "R9 addr3");

    // R1: fastest rate with a pulse every cycle, then code 6 every other cycle
    tdiv = 1;
    wreg(2'd0, 8'h23);
    wreg(2'd1, 8'h48);
    run(21);
    rreg(2'd2, "R1 code3 flags");
    run(9);
    rreg(2'd2, "R1 code3 flags again");
    tdiv = 2;
    wreg(2'd0, 8'h26);
    run(200);
    rreg(2'd2, "R1 code6 flags");
    run(90);

    // R2: special low codes
    tdiv = 1;
    wreg(2'd0, 8'h21);
    run(300);
    rreg(2'd2, "R2 code1 flags");
    wreg(2'd0, 8'h22);
    run(600);
    rreg(2'd2, "R2 code2 flags");

    // R3: code 0 is silent
    wreg(2'd0, 8'h20);
    rreg(2'd2, "R3 clear");
    run(500);
    rreg(2'd2, "R3 code0 no periodic flag");

    // R4: hold codes clear the prescaler, other bases freeze it
    wreg(2'd0, 8'h25);
    run(37);
    wreg(2'd0, 8'h65);
    run(5);
    wreg(2'd0, 8'h25);
    run(15);
    rreg(2'd2, "R4 no early event");
    run(20);
    rreg(2'd2, "R4 event after full period");
    run(7);
    wreg(2'd0, 8'h75);
    run(3);
    wreg(2'd0, 8'h05);
    run(40);
    wreg(2'd0, 8'h25);
    run(40);
    rreg(2'd2, "R4 freeze then resume");

    // R5 and R6: flags without enables, then enables drive irq
    wreg(2'd1, 8'h00);
    wreg(2'd0, 8'h20);
    rreg(2'd2, "R5 clear");
    cyc(nt(), 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, "");
    cyc(nt(), 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'd0, "");
    rreg(2'd2, "R5 flags with enables off");
    cyc(nt(), 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, "");
    wreg(2'd1, 8'h10);
    run(2);
    wreg(2'd1, 8'h20);
    run(2);
    rreg(2'd2, "R6 alarm enabled irq bit");
    run(2);

    // R7: event in the same cycle as the read survives
    cyc(nt(), 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, "");
    cyc(nt(), 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 8'd0, "R7 read with event");
    rreg(2'd2, "R7 surviving flags");
    rreg(2'd2, "R7 cleared");

    // R8: slowest rate, full square-wave period with and without enable
    wreg(2'd0, 8'h2F);
    wreg(2'd1, 8'h08);
    run(33000);
    wreg(2'd1, 8'h40);
    run(300);
    rreg(2'd2, "R8 slow rate flags");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule